// File: doc/BRIEF.md
# Byte-Packed Data FIFO Engine

This block sits between a 32-bit register window and a byte-wide card data port. Software-side accesses of one to four bytes are packed into, or unpacked from, two byte FIFOs: a circular receive buffer of `DEPTH` bytes, and a transmit buffer built from two halves of `DEPTH` bytes each. In every access the earliest byte sits in the most significant lane the access uses. A transfer begins with a start pulse that carries a direction and a byte count. From then on the engine moves at most one byte per clock over a valid/ready handshake, until the count reaches zero. While it works it raises FIFO service requests, and when it finishes it sets completion flags.

The controller is a four-state machine. `ST_IDLE` waits for a start. A start enters `ST_FETCH` for a read or `ST_DRAIN` for a write, and a start pulse arriving in any state restarts the transfer. `ST_FETCH` pulls card bytes while the count is nonzero and the receive buffer has room. `ST_DRAIN` pushes bytes to the card while the count is nonzero and the transmit buffer holds data. Either state moves to `ST_FINISH` when the count is already zero, or when the handshake that carries the last byte fires. `ST_FINISH` sets the completion flags and returns to `ST_IDLE` one clock later.

Top module: `byte_fifo_engine`

## Requirements
- R1: In reset and on leaving it, `active`, every bit of `int_req` and `stat_word`, `rx_count`, `tx_count`, `card_rx_ready` and `card_tx_valid` are all 0.
- R2: A start pulse clears both FIFO fill counts, loads the byte counter, and clears the done flags. It then raises `active` and selects drain when `xfer_write` is 1 and fetch when it is 0.
- R3: During a read transfer, `card_rx_ready` is 1 only while the byte counter is nonzero and `rx_count` is below `DEPTH`, so the receive buffer stops filling at `DEPTH` bytes.
- R4: `acc_size` gives the access width in bytes (1 to 4; 0 moves no bytes; values above 4 act as 4). A receive read of N bytes returns the oldest byte in lane N-1 (bits 8N-1..8N-8), the following bytes in the lanes below it, and zeros in the lanes above, on `rx_rd_data` one clock later. It removes min(N, `rx_count`) bytes.
- R5: Lanes for which the receive buffer has no byte read as zero. A read of an empty buffer leaves `rx_count` at zero.
- R6: `int_req` bit 5 (receive request) is set by every byte taken from the card and cleared by a receive read. A fetch in the same clock takes priority over the clear.
- R7: A transmit write of N bytes stores lane N-1 first and the lanes below it after. Bytes that would take the fill count past `DEPTH` are dropped.
- R8: During a write transfer, bytes leave for the card in the order they were stored, one per accepted handshake, while the counter is nonzero and the buffer is not empty.
- R9: `int_req` bit 6 (transmit request) is set while a write transfer has bytes left and an empty transmit buffer. It is cleared by a transmit write.
- R10: When the counter reaches zero, `active` drops and `int_req` bit 0 and `stat_word` bit 11 (data done) are set. A write transfer also sets `int_req` bit 1 and `stat_word` bit 12 (program done).
- R11: A `tx_flush` pulse switches the transmit buffer to its other half and empties it. Only bytes written afterwards reach the card.
- R12: A start with a byte count of zero finishes without moving any byte: `active` drops and the done flags appear two clocks after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Start pulse for a transfer |
| xfer_write | input | 1 | Direction: 1 writes to the card, 0 reads from it |
| xfer_bytes | input | CNT_W | Byte count loaded at start |
| acc_size | input | 3 | Register access width in bytes |
| tx_wr_en | input | 1 | Transmit register write strobe |
| tx_wr_data | input | 32 | Transmit register write data |
| rx_rd_en | input | 1 | Receive register read strobe |
| rx_rd_data | output | 32 | Packed receive data, valid one clock after the read |
| tx_flush | input | 1 | Switch to the other transmit half and discard its contents |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_ready | output | 1 | Engine accepts a card byte |
| card_tx_valid | output | 1 | Engine offers a byte to the card |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card accepts the byte |
| active | output | 1 | Transfer in progress |
| int_req | output | 7 | Requests: bit0 data done, bit1 program done, bit5 receive request, bit6 transmit request |
| stat_word | output | 13 | Status: bit11 data done, bit12 program done |
| rx_count | output | $clog2(DEPTH)+1 | Receive buffer fill level |
| tx_count | output | $clog2(DEPTH)+1 | Transmit buffer fill level |

## Verification
The packed receive word appears one clock after the read strobe. The bench drives the strobe at a falling edge, records the fill level at that moment, and reads the word at the next falling edge. Request flags change at the edge that follows their cause, and completion flags appear one clock after the state machine reaches `ST_FINISH`. Checks on these flags are therefore made either after a counted number of falling edges (two for a zero-length start) or after `active` has been polled low. Card handshakes are resolved at the falling edge that sets the ready or valid, where the byte that will cross at the next rising edge is already stable, so every drained byte is compared in the cycle it leaves.

// File: rtl/bfe_pkg.sv
package bfe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_FINISH = 2'd3
    } bfe_state_e;

    localparam int LANES      = 4;
    localparam int IRQ_W      = 7;
    localparam int STAT_W     = 13;
    localparam int IRQ_DONE   = 0;
    localparam int IRQ_PRG    = 1;
    localparam int IRQ_RXREQ  = 5;
    localparam int IRQ_TXREQ  = 6;
    localparam int STAT_DONE  = 11;
    localparam int STAT_PRG   = 12;

    function automatic logic [2:0] clamp_size(input logic [2:0] s);
        return (s > 3'd4) ? 3'd4 : s;
    endfunction

endpackage

// File: rtl/bfe_rx_fifo.sv
module bfe_rx_fifo #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push_en,
    input  logic [7:0]    push_byte,
    input  logic          pop_en,
    input  logic [2:0]    pop_size,
    output logic [31:0]   pop_word,
    output logic [CW-1:0] count
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] start_q;
    logic [CW-1:0] cnt_q;
    logic [2:0]    pop_n;
    logic [2:0]    pop_used;

    // Oldest byte goes to the highest lane used by the access.
    always_comb begin
        pop_word = '0;
        pop_n    = '0;
        for (int i = 0; i < bfe_pkg::LANES; i++) begin
            if (i < int'(pop_size) && i < int'(cnt_q)) begin
                pop_word = pop_word |
                    ({24'd0, mem[start_q + AW'(i)]} << (8 * (int'(pop_size) - 1 - i)));
                pop_n = pop_n + 3'd1;
            end
        end
    end

    assign pop_used = pop_en ? pop_n : 3'd0;
    assign count    = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
        end else if (clear) begin
            cnt_q   <= '0;
        end else begin
            start_q <= start_q + AW'(pop_used);
            cnt_q   <= cnt_q + CW'(push_en) - CW'(pop_used);
        end
    end

    always_ff @(posedge clk) begin
        if (push_en && !clear)
            mem[start_q + AW'(cnt_q)] <= push_byte;
    end
endmodule

// File: rtl/bfe_tx_fifo.sv
module bfe_tx_fifo #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          flush,
    input  logic          push_en,
    input  logic [2:0]    push_size,
    input  logic [31:0]   push_word,
    input  logic          pop_en,
    output logic [7:0]    head,
    output logic [CW-1:0] count
);
    // Two halves: the top pointer bit selects the half, the low bits wrap inside it.
    logic [7:0]    mem [2*DEPTH];
    logic [AW:0]   start_q;
    logic [CW-1:0] cnt_q;
    logic [bfe_pkg::LANES-1:0] wr_en;
    logic [AW:0]   wr_addr [bfe_pkg::LANES];
    logic [7:0]    wr_byte [bfe_pkg::LANES];
    logic [2:0]    push_n;

    always_comb begin
        push_n = '0;
        for (int i = 0; i < bfe_pkg::LANES; i++) begin
            wr_en[i]   = 1'b0;
            wr_addr[i] = {start_q[AW], start_q[AW-1:0] + AW'(cnt_q) + AW'(i)};
            wr_byte[i] = '0;
            if (i < int'(push_size) && (int'(cnt_q) + i) < DEPTH) begin
                wr_en[i]   = push_en;
                wr_byte[i] = 8'(push_word >> (8 * (int'(push_size) - 1 - i)));
                push_n     = push_n + 3'd1;
            end
        end
    end

    assign head  = mem[start_q];
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
        end else if (clear) begin
            cnt_q   <= '0;
        end else if (flush) begin
            start_q[AW] <= ~start_q[AW];
            cnt_q       <= '0;
        end else begin
            if (pop_en)
                start_q[AW-1:0] <= start_q[AW-1:0] + AW'(1);
            cnt_q <= cnt_q + (push_en ? CW'(push_n) : CW'(0)) - CW'(pop_en);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < bfe_pkg::LANES; i++) begin
            if (wr_en[i] && !clear && !flush)
                mem[wr_addr[i]] <= wr_byte[i];
        end
    end
endmodule

// File: rtl/bfe_ctrl.sv
module bfe_ctrl
    import bfe_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               dir_write,
    input  logic [CNT_W-1:0]   load_bytes,
    input  logic               fetch_fire,
    input  logic               drain_fire,
    input  logic               rx_read,
    input  logic               tx_write,
    input  logic               tx_empty,
    output bfe_state_e         state,
    output logic               left_nz,
    output logic [IRQ_W-1:0]   int_req,
    output logic [STAT_W-1:0]  stat_word
);
    bfe_state_e       state_q, state_d;
    logic [CNT_W-1:0] left_q;
    logic             dir_q;
    logic             done_q, prg_q, rxreq_q, txreq_q;
    logic             last_byte;

    assign last_byte = (left_q == CNT_W'(1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_IDLE;
            ST_FETCH:  if (left_q == '0 || (fetch_fire && last_byte)) state_d = ST_FINISH;
            ST_DRAIN:  if (left_q == '0 || (drain_fire && last_byte)) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
        if (start)
            state_d = dir_write ? ST_DRAIN : ST_FETCH;
    end

    // Counter, direction and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            dir_q   <= 1'b0;
            done_q  <= 1'b0;
            prg_q   <= 1'b0;
            rxreq_q <= 1'b0;
            txreq_q <= 1'b0;
        end else begin
            if (start) begin
                left_q <= load_bytes;
                dir_q  <= dir_write;
            end else if (fetch_fire || drain_fire) begin
                left_q <= left_q - CNT_W'(1);
            end

            if (start) begin
                done_q <= 1'b0;
                prg_q  <= 1'b0;
            end else if (state_q == ST_FINISH) begin
                done_q <= 1'b1;
                if (dir_q) prg_q <= 1'b1;
            end

            if (fetch_fire)   rxreq_q <= 1'b1;
            else if (rx_read) rxreq_q <= 1'b0;

            if (tx_write)
                txreq_q <= 1'b0;
            else if (state_q == ST_DRAIN && left_q != '0 && tx_empty)
                txreq_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        state     = state_q;
        left_nz   = (left_q != '0);
        int_req   = '0;
        stat_word = '0;
        int_req[IRQ_DONE]    = done_q;
        int_req[IRQ_PRG]     = prg_q;
        int_req[IRQ_RXREQ]   = rxreq_q;
        int_req[IRQ_TXREQ]   = txreq_q;
        stat_word[STAT_DONE] = done_q;
        stat_word[STAT_PRG]  = prg_q;
    end
endmodule

// File: rtl/byte_fifo_engine.sv
module byte_fifo_engine
    import bfe_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 28,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xfer_start,
    input  logic                xfer_write,
    input  logic [CNT_W-1:0]    xfer_bytes,
    input  logic [2:0]          acc_size,
    input  logic                tx_wr_en,
    input  logic [31:0]         tx_wr_data,
    input  logic                rx_rd_en,
    output logic [31:0]         rx_rd_data,
    input  logic                tx_flush,
    input  logic                card_rx_valid,
    input  logic [7:0]          card_rx_data,
    output logic                card_rx_ready,
    output logic                card_tx_valid,
    output logic [7:0]          card_tx_data,
    input  logic                card_tx_ready,
    output logic                active,
    output logic [IRQ_W-1:0]    int_req,
    output logic [STAT_W-1:0]   stat_word,
    output logic [CW-1:0]       rx_count,
    output logic [CW-1:0]       tx_count
);
    bfe_state_e  state;
    logic        left_nz;
    logic        fetch_fire, drain_fire;
    logic [2:0]  size_c;
    logic [31:0] rx_word;

    assign size_c        = clamp_size(acc_size);
    assign active        = (state != ST_IDLE);
    assign card_rx_ready = (state == ST_FETCH) && left_nz && (rx_count < CW'(DEPTH));
    assign card_tx_valid = (state == ST_DRAIN) && left_nz && (tx_count != '0);
    assign fetch_fire    = card_rx_valid && card_rx_ready;
    assign drain_fire    = card_tx_valid && card_tx_ready;

    bfe_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (xfer_start),
        .dir_write  (xfer_write),
        .load_bytes (xfer_bytes),
        .fetch_fire (fetch_fire),
        .drain_fire (drain_fire),
        .rx_read    (rx_rd_en),
        .tx_write   (tx_wr_en),
        .tx_empty   (tx_count == '0),
        .state      (state),
        .left_nz    (left_nz),
        .int_req    (int_req),
        .stat_word  (stat_word)
    );

    bfe_rx_fifo #(.DEPTH(DEPTH)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (xfer_start),
        .push_en   (fetch_fire),
        .push_byte (card_rx_data),
        .pop_en    (rx_rd_en),
        .pop_size  (size_c),
        .pop_word  (rx_word),
        .count     (rx_count)
    );

    bfe_tx_fifo #(.DEPTH(DEPTH)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (xfer_start),
        .flush     (tx_flush),
        .push_en   (tx_wr_en),
        .push_size (size_c),
        .push_word (tx_wr_data),
        .pop_en    (drain_fire),
        .head      (card_tx_data),
        .count     (tx_count)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        rx_rd_data <= '0;
        else if (rx_rd_en) rx_rd_data <= rx_word;
    end
endmodule

// File: rtl/bfe_checker.sv
module bfe_checker #(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_start,
    input logic          tx_wr_en,
    input logic          rx_rd_en,
    input logic          card_rx_valid,
    input logic          card_rx_ready,
    input logic          card_tx_valid,
    input logic          active,
    input logic [6:0]    int_req,
    input logic [12:0]   stat_word,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count
);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(DEPTH));
    p_fetch_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        card_rx_ready |-> (active && rx_count < CW'(DEPTH)));
    p_drain_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        card_tx_valid |-> (active && tx_count != '0));
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> (active && !int_req[0] && rx_count == '0));
    p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_en && rx_count == '0 && !(card_rx_valid && card_rx_ready) && !xfer_start)
        |=> rx_count == '0);
    p_rxreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rx_valid && card_rx_ready) |=> int_req[5]);
    p_txreq_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_en |=> !int_req[6]);
    p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> (int_req[0] && stat_word[11]));
    p_prg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_req[1]) |-> (int_req[0] && stat_word[12]));
endmodule

bind byte_fifo_engine bfe_checker #(.DEPTH(DEPTH)) u_bfe_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .xfer_start    (xfer_start),
    .tx_wr_en      (tx_wr_en),
    .rx_rd_en      (rx_rd_en),
    .card_rx_valid (card_rx_valid),
    .card_rx_ready (card_rx_ready),
    .card_tx_valid (card_tx_valid),
    .active        (active),
    .int_req       (int_req),
    .stat_word     (stat_word),
    .rx_count      (rx_count),
    .tx_count      (tx_count)
);

// File: tb/test_byte_fifo_engine.sv
module test_byte_fifo_engine;
    localparam int DEPTH = 32;
    localparam int CNT_W = 28;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic             xfer_start = 0, xfer_write = 0;
    logic [CNT_W-1:0] xfer_bytes = '0;
    logic [2:0]       acc_size = 3'd4;
    logic             tx_wr_en = 0, rx_rd_en = 0, tx_flush = 0;
    logic [31:0]      tx_wr_data = '0;
    logic [31:0]      rx_rd_data;
    logic             card_rx_valid = 0, card_rx_ready;
    logic [7:0]       card_rx_data;
    logic             card_tx_valid, card_tx_ready = 0;
    logic [7:0]       card_tx_data;
    logic             active;
    logic [6:0]       int_req;
    logic [12:0]      stat_word;
    logic [CW-1:0]    rx_count, tx_count;

    byte_fifo_engine #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_byte_fifo_engine (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_write(xfer_write),
        .xfer_bytes(xfer_bytes), .acc_size(acc_size), .tx_wr_en(tx_wr_en),
        .tx_wr_data(tx_wr_data), .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .tx_flush(tx_flush), .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
        .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
        .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready), .active(active),
        .int_req(int_req), .stat_word(stat_word), .rx_count(rx_count), .tx_count(tx_count)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rx_byte(input int k);
        return 8'((k * 29 + 7) ^ (k >>> 3));
    endfunction

    function automatic logic [31:0] pack_exp(input int base, input int sz, input int avail);
        logic [31:0] w = '0;
        int n = (sz > 4) ? 4 : sz;
        for (int i = 0; i < n; i++)
            if (i < avail) w = w | ({24'd0, rx_byte(base + i)} << (8 * (n - 1 - i)));
        return w;
    endfunction

    // Card source: handshake resolved at the falling edge before the rising edge that moves it.
    int rx_src = 0;
    bit rx_pend = 0;
    assign card_rx_data = rx_byte(rx_src);
    always @(negedge clk) begin
        if (rx_pend) rx_src++;
        card_rx_valid = ($urandom % 3) != 0;
        rx_pend = card_rx_valid && card_rx_ready && rst_n;
    end

    // Card sink with byte comparison.
    logic [7:0] exp_tx [1024];
    int exp_wr = 0, tx_sink = 0;
    bit tx_hold = 1;
    always @(negedge clk) begin
        card_tx_ready = tx_hold ? 1'b0 : 1'(($urandom % 2) != 0);
        if (card_tx_ready && card_tx_valid && rst_n) begin
            chk(card_tx_data == exp_tx[tx_sink % 1024], "R7 R8 byte order",
                card_tx_data, exp_tx[tx_sink % 1024]);
            tx_sink++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start(input bit wr, input int n);
        @(negedge clk);
        xfer_start = 1; xfer_write = wr; xfer_bytes = CNT_W'(n);
        if (wr) exp_wr = tx_sink;
        @(negedge clk);
        xfer_start = 0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 5000 && active; g++) tick(1);
    endtask

    task automatic rx_read(input int sz, output logic [31:0] got, output int avail);
        @(negedge clk);
        rx_rd_en = 1; acc_size = 3'(sz); avail = int'(rx_count);
        @(negedge clk);
        rx_rd_en = 0;
        got = rx_rd_data;
    endtask

    task automatic tx_write(input int sz, input logic [31:0] w);
        int cnt;
        @(negedge clk);
        tx_wr_en = 1; acc_size = 3'(sz); tx_wr_data = w; cnt = int'(tx_count);
        for (int i = 0; i < sz; i++)
            if (cnt + i < DEPTH) begin
                exp_tx[exp_wr % 1024] = 8'(w >> (8 * (sz - 1 - i)));
                exp_wr++;
            end
        @(negedge clk);
        tx_wr_en = 0;
    endtask

    int rd_ptr = 0;

    task automatic run_rx(input int n, input bit stall);
        int got_n = 0, avail, sz, take;
        logic [31:0] got;
        do_start(0, n);
        chk(active == 1 && int_req[0] == 0, "R2 start state", {active, int_req[0]}, 2'b10);
        if (stall) begin
            tick(3 * DEPTH + 20);
            chk(rx_count == CW'(DEPTH), "R3 fill limit", rx_count, DEPTH);
            chk(card_rx_ready == 0, "R3 ready low when full", card_rx_ready, 0);
            chk(int_req[5] == 1, "R6 rx request set", int_req[5], 1);
        end
        for (int g = 0; g < 20000 && got_n < n; g++) begin
            if (rx_count == '0) tick(1);
            else begin
                sz = 1 + int'($urandom % 4);
                rx_read(sz, got, avail);
                take = (sz < avail) ? sz : avail;
                chk(got == pack_exp(rd_ptr, sz, avail), "R4 R5 packing", got, pack_exp(rd_ptr, sz, avail));
                rd_ptr += take; got_n += take;
            end
        end
        wait_idle();
        chk(int_req[0] && stat_word[11] && !int_req[1] && !stat_word[12], "R10 read done flags",
            {int_req[1:0], stat_word[12:11]}, 4'b0101);
    endtask

    task automatic run_tx(input int n);
        int written = 0, sz, sink0;
        bit first = 1;
        tx_hold = 0;
        do_start(1, n);
        sink0 = tx_sink;
        tick(3);
        chk(int_req[6] == 1, "R9 tx request set", int_req[6], 1);
        for (int g = 0; g < 20000 && written < n; g++) begin
            sz = 1 + int'($urandom % 4);
            if (sz > n - written) sz = n - written;
            if (int'(tx_count) + sz <= DEPTH) begin
                tx_write(sz, $urandom);
                written += sz;
                if (first) chk(int_req[6] == 0, "R9 tx request cleared", int_req[6], 0);
                first = 0;
            end else tick(1);
        end
        wait_idle();
        chk(tx_sink - sink0 == n, "R8 drained count", tx_sink - sink0, n);
        chk(int_req[1:0] == 2'b11 && stat_word[12:11] == 2'b11, "R10 write done flags",
            {int_req[1:0], stat_word[12:11]}, 4'b1111);
    endtask

    initial begin
        logic [31:0] got;
        int avail, sink0;
        void'($urandom(32'd20240611));
        tick(4);
        chk(active == 0 && int_req == '0 && stat_word == '0, "R1 reset flags", {active, int_req}, 0);
        chk(rx_count == '0 && tx_count == '0, "R1 reset counts", {rx_count, tx_count}, 0);
        chk(card_rx_ready == 0 && card_tx_valid == 0, "R1 reset handshake", {card_rx_ready, card_tx_valid}, 0);
        rst_n = 1;
        tick(2);

        // Read transfer larger than the buffer, held full first
        run_rx(40, 1);

        // Partial and empty receive reads
        do_start(0, 1);
        wait_idle();
        chk(int_req[5] == 1, "R6 rx request after fetch", int_req[5], 1);
        rx_read(4, got, avail);
        chk(got == {rx_byte(rd_ptr), 24'd0}, "R5 missing lanes zero", got, {rx_byte(rd_ptr), 24'd0});
        rd_ptr++;
        chk(int_req[5] == 0, "R6 rx request cleared by read", int_req[5], 0);
        rx_read(2, got, avail);
        chk(got == 0, "R5 empty read data", got, 0);
        chk(rx_count == '0, "R5 empty read count", rx_count, 0);

        // Write transfer
        run_tx(37);

        // Overflow while idle: extra bytes dropped
        tx_hold = 1;
        for (int k = 0; k < 9; k++) tx_write(4, 32'hC0DE0000 + k);
        chk(tx_count == CW'(DEPTH), "R7 overflow dropped", tx_count, DEPTH);

        // Flush during a held write transfer
        do_start(1, 8);
        sink0 = tx_sink;
        tx_write(4, 32'h11223344);
        @(negedge clk); tx_flush = 1;
        @(negedge clk); tx_flush = 0;
        chk(tx_count == '0, "R11 flush empties", tx_count, 0);
        exp_wr = tx_sink;
        tx_write(4, 32'hA1B2C3D4);
        tx_write(4, 32'hE5F60718);
        tx_hold = 0;
        wait_idle();
        chk(tx_sink - sink0 == 8, "R11 only new bytes sent", tx_sink - sink0, 8);

        // Zero-length transfer
        do_start(0, 0);
        tick(2);
        chk(!active && int_req[0] && stat_word[11], "R12 zero length done", {active, int_req[0], stat_word[11]}, 3'b011);

        // Random mix
        for (int r = 0; r < 6; r++) begin
            if ($urandom % 2) run_rx(1 + int'($urandom % 60), 0);
            else              run_tx(1 + int'($urandom % 60));
        end

        tick(4);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule